// File: doc/BRIEF.md
# SAR Conversion Sequencer with Serial Output

This block is the digital controller of a successive-approximation converter. It runs entirely on the serial clock that the host provides. A rising edge on the conversion request starts a conversion. The sequencer then puts the converter into hold and builds the result in a trial register, one bit per clock. It starts at the most significant bit and finishes at the least significant bit. The trial register drives the DAC port. An external single-bit comparator tells the sequencer whether the present trial code is at or below the held input.

Each bit decision goes onto the serial data line as soon as it is made, so the host receives the word while the conversion is still running. The serial word opens with a reference-ready status bit and is followed by the result, most significant bit first. In bipolar mode the result is sent in two's complement form. The line is released (output enable low) before and after the word.

The conversion request is sampled on the falling clock edge. A request that rises in the second half of a clock period therefore starts one clock later, and the whole output word moves by one clock.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, the output enable is low, hold is low, done is low and the DAC code is zero.
- R2: A rise of conv_i is captured on the falling clock edge. A rise that comes before the falling edge of a clock period starts the conversion on the next rising edge (P0). A rise that comes after that falling edge starts the conversion one rising edge later.
- R3: At P0, hold_o goes high and the trial code is cleared to a single 1 in the most significant bit (0x800 for 12 bits).
- R4: On rising edges P1 to P12, one bit is decided per edge, from bit 11 down to bit 0. The bit under trial is kept when cmp_i is 1 (DAC code not above the held input) and is cleared otherwise. The next lower bit is then set as the new trial bit.
- R5: While the word is out, the serial data carries the reference-ready bit after P0 and the decision for bit 11-k after edge P(k+1). The receiver samples it on the rising edge.
- R6: When bipolar_i is 1, the first result bit sent is the inverse of the bit 11 decision, so the serial word is two's complement. The DAC code is not affected.
- R7: done_o is high for exactly one clock, starting at P12 together with the last result bit.
- R8: At P13 the output enable drops, hold_o returns low, and dac_o keeps the final result.
- R9: A conv_i rise that is detected while a conversion is running (P0 to P13) is ignored and does not restart or extend the conversion.
- R10: The reference-ready bit is the value of ref_rdy_i sampled at P0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| conv_i | input | 1 | Conversion request; a rising edge starts a conversion |
| cmp_i | input | 1 | Comparator: 1 when the DAC code is at or below the held input |
| ref_rdy_i | input | 1 | Reference settled status, sent as the first bit of the word |
| bipolar_i | input | 1 | 1 selects a two's-complement result on the serial line |
| dac_o | output | 12 | Trial code to the DAC; after a conversion it holds the result |
| hold_o | output | 1 | 1 = hold, 0 = sample/acquire |
| done_o | output | 1 | One-clock pulse with the last result bit |
| dout_o | output | 1 | Serial data |
| dout_oe_o | output | 1 | Enable for the three-state pad driver of dout_o |

## Verification
The case that needs the most care is a new conversion request that arrives while the sequencer is finishing the previous one. Such a rise is detected on the same edge where a bit decision is made, or where the release cycle runs, and the sequencer must ignore it. The bench provokes this by dropping and raising conv_i in the middle of a conversion. A reference model advances the expected bit counter on every clock and compares it with the design. After the release, hold and the enable must stay low, and the final word must be unchanged. Early and late request edges are also mixed, so that the start edge falls on either side of the falling-edge capture point.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int unsigned DEF_WIDTH = 12;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DECIDE = 2'd1,
    ST_LAST   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/conv_edge.sv
module conv_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic conv_i,
  output logic rise_o
);
  logic conv_n_q, conv_d_q;

  // falling-edge capture sets the setup window to half a clock
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) conv_n_q <= 1'b0;
    else         conv_n_q <= conv_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) conv_d_q <= 1'b0;
    else         conv_d_q <= conv_n_q;
  end

  assign rise_o = conv_n_q & ~conv_d_q;

  a_r2_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             cmp_i,
  output logic             start_o,
  output logic             dec_vld_o,
  output logic             dec_bit_o,
  output logic             dec_msb_o,
  output logic             finish_o,
  output logic [WIDTH-1:0] trial_o,
  output logic             hold_o,
  output logic             done_o
);
  localparam int unsigned IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [WIDTH-1:0] MSB_ONE = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [IDXW-1:0]  TOP_IDX = IDXW'(WIDTH - 1);

  seq_state_e       state_q;
  logic [IDXW-1:0]  idx_q;
  logic [WIDTH-1:0] sar_q, sar_nxt;
  logic             hold_q, done_q;

  // per-bit update: decided bit takes cmp, next lower bit becomes trial
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_comb begin
      if (int'(idx_q) == g)          sar_nxt[g] = cmp_i;
      else if (int'(idx_q) == g + 1) sar_nxt[g] = 1'b1;
      else                           sar_nxt[g] = sar_q[g];
    end
  end

  assign start_o = (state_q == ST_IDLE) && rise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      sar_q   <= '0;
      hold_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (rise_i) begin
            state_q <= ST_DECIDE;
            sar_q   <= MSB_ONE;
            idx_q   <= TOP_IDX;
            hold_q  <= 1'b1;
          end
        end
        ST_DECIDE: begin
          sar_q <= sar_nxt;
          if (idx_q == '0) begin
            state_q <= ST_LAST;
            done_q  <= 1'b1;
          end else begin
            idx_q <= idx_q - IDXW'(1);
          end
        end
        ST_LAST: begin
          state_q <= ST_IDLE;
          hold_q  <= 1'b0;
          done_q  <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dec_vld_o = (state_q == ST_DECIDE);
  assign dec_bit_o = cmp_i;
  assign dec_msb_o = (idx_q == TOP_IDX);
  assign finish_o  = (state_q == ST_LAST);
  assign trial_o   = sar_q;
  assign hold_o    = hold_q;
  assign done_o    = done_q;

  a_r3_msb_trial: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_q) |-> (sar_q == MSB_ONE));
  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  a_r8_hold_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !hold_q);
  a_r9_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DECIDE) |=> hold_q);
  a_r8_result_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish_o |=> $stable(sar_q));
endmodule

// File: rtl/ser_out.sv
module ser_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic rdy_i,
  input  logic bipolar_i,
  input  logic dec_vld_i,
  input  logic dec_bit_i,
  input  logic dec_msb_i,
  input  logic finish_i,
  input  logic hold_i,
  input  logic done_i,
  output logic dout_o,
  output logic oe_o
);
  logic d_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_q  <= 1'b0;
      oe_q <= 1'b0;
    end else if (start_i) begin
      d_q  <= rdy_i;
      oe_q <= 1'b1;
    end else if (dec_vld_i) begin
      // inverting the MSB turns offset binary into two's complement
      d_q <= dec_bit_i ^ (bipolar_i & dec_msb_i);
    end else if (finish_i) begin
      d_q  <= 1'b0;
      oe_q <= 1'b0;
    end
  end

  assign dout_o = d_q;
  assign oe_o   = oe_q;

  a_r5_oe_with_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |-> oe_q);
  a_r8_float_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !oe_q);
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             conv_i,
  input  logic             cmp_i,
  input  logic             ref_rdy_i,
  input  logic             bipolar_i,
  output logic [WIDTH-1:0] dac_o,
  output logic             hold_o,
  output logic             done_o,
  output logic             dout_o,
  output logic             dout_oe_o
);
  logic rise, start, dec_vld, dec_bit, dec_msb, finish;

  conv_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .conv_i (conv_i),
    .rise_o (rise)
  );

  sar_seq #(.WIDTH(WIDTH)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rise),
    .cmp_i     (cmp_i),
    .start_o   (start),
    .dec_vld_o (dec_vld),
    .dec_bit_o (dec_bit),
    .dec_msb_o (dec_msb),
    .finish_o  (finish),
    .trial_o   (dac_o),
    .hold_o    (hold_o),
    .done_o    (done_o)
  );

  ser_out u_ser (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .rdy_i     (ref_rdy_i),
    .bipolar_i (bipolar_i),
    .dec_vld_i (dec_vld),
    .dec_bit_i (dec_bit),
    .dec_msb_i (dec_msb),
    .finish_i  (finish),
    .hold_i    (hold_o),
    .done_i    (done_o),
    .dout_o    (dout_o),
    .oe_o      (dout_oe_o)
  );
endmodule

// File: tb/tb_sar_conv_seq.sv
module tb_sar_conv_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic conv = 1'b0, ref_rdy = 1'b0, bipolar = 1'b0;
  logic [11:0] dac;
  logic hold, done, dout, dout_oe, cmp;
  int vin_code = 0;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  assign cmp = (int'(dac) <= vin_code);

  sar_conv_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .conv_i(conv), .cmp_i(cmp),
    .ref_rdy_i(ref_rdy), .bipolar_i(bipolar), .dac_o(dac),
    .hold_o(hold), .done_o(done), .dout_o(dout), .dout_oe_o(dout_oe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit mc_n, mc_d, m_en, m_d, m_hold, m_done, rise, b;
  int step = -1, bp;
  logic [11:0] m_code = '0;

  always @(negedge clk) mc_n = rst_n ? conv : 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_d = 0; step = -1; m_code = '0; m_en = 0; m_d = 0; m_hold = 0; m_done = 0;
    end else begin
      rise = mc_n && !mc_d;
      mc_d = mc_n;
      if (step < 0) begin
        if (rise) begin
          step = 0; m_code = 12'h800; m_d = ref_rdy; m_en = 1; m_hold = 1; m_done = 0;
        end
      end else if (step < 12) begin
        bp = 11 - step;
        b = (int'(m_code) <= vin_code);
        m_code[bp] = b;
        if (bp > 0) m_code[bp-1] = 1'b1;
        m_d = b ^ (bipolar && bp == 11);
        m_done = (bp == 0);
        step++;
      end else begin
        step = -1; m_en = 0; m_d = 0; m_hold = 0; m_done = 0;
      end
    end
  end

  always @(posedge clk) begin
    #3;
    if (rst_n && !finished) begin
      chk("R4 dac vs model", int'(dac), int'(m_code));
      chk("R8 enable vs model", int'(dout_oe), int'(m_en));
      if (m_en) chk("R5 dout vs model", int'(dout), int'(m_d));
      chk("R3 hold vs model", int'(hold), int'(m_hold));
      chk("R7 done vs model", int'(done), int'(m_done));
    end
  end

  task automatic run_conv(input int vin_s, input bit bip, input bit rdy,
                          input bit late, input bit glitch);
    int n;
    logic [11:0] word;
    int exp;
    vin_code = bip ? vin_s + 2048 : vin_s;
    bipolar = bip;
    ref_rdy = rdy;
    @(posedge clk);
    #(late ? 15 : 5) conv = 1'b1;
    n = 0;
    do begin
      @(posedge clk); #3; n++;
    end while (!hold && n < 5);
    chk("R2 start latency", n, late ? 2 : 1);
    chk("R3 trial msb at start", int'(dac), 2048);
    chk("R10 ready bit", dout_oe ? int'(dout) : 2, int'(rdy));
    word = '0;
    for (int i = 0; i < 12; i++) begin
      @(posedge clk); #3;
      word = {word[10:0], dout};
      if (glitch && i == 5) begin
        conv = 1'b0; #10; conv = 1'b1;
      end
    end
    exp = vin_s & 12'hFFF;
    if (bip) chk("R6 two's complement word", int'(word), exp);
    else     chk("R5 serial word", int'(word), exp);
    chk("R7 done with last bit", int'(done), 1);
    @(posedge clk); #3;
    chk("R8 line released", int'(dout_oe), 0);
    chk("R8 hold released", int'(hold), 0);
    chk("R8 result kept", int'(dac), vin_code);
    if (glitch) begin
      for (int k = 0; k < 3; k++) begin
        @(posedge clk); #3;
        chk("R9 ignored rise no restart", int'(hold) + int'(dout_oe), 0);
      end
    end
    conv = 1'b0;
    repeat (2) @(posedge clk);
    #2;
  endtask

  initial begin
    #45 rst_n = 1'b1;
    @(posedge clk); #3;
    chk("R1 reset enable", int'(dout_oe), 0);
    chk("R1 reset hold", int'(hold), 0);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset dac", int'(dac), 0);
    repeat (2) @(posedge clk);
    #2;
    run_conv(3046, 0, 1, 0, 0);
    run_conv(0,    0, 1, 1, 0);
    run_conv(4095, 0, 0, 0, 0);
    run_conv(1,    0, 1, 1, 1);
    run_conv(2048, 0, 1, 0, 0);
    run_conv(-2048, 1, 1, 0, 0);
    run_conv(2047,  1, 0, 1, 0);
    run_conv(-1,    1, 1, 0, 1);
    run_conv(0,     1, 1, 1, 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1;
      chk("watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule